// File: doc/BRIEF.md
# Serial Flash Controller Interrupt, FIFO Status and Recovery Unit

This block is the status and recovery register group that sits beside a serial flash sequencer. Eight event sources are recorded in a raw status register. They stay recorded until software writes ones to a clear register. A mask register gates the raw bits into a masked status view and a single interrupt line. An event that arrives in the same cycle as a clear of the same bit is kept.

The unit also owns the data FIFO that the sequencer and the register side share. One storage array of 32-bit words serves both directions, so the transmit and receive level fields always report the same occupancy. Four of the eight event sources come from this FIFO: fill to full, pop while empty, push while full, and drain to empty. The other four come in from the sequencer. The FIFO status word packs full and empty flags together with both level fields. A threshold register holds a transmit and a receive watermark for software.

Writing the recovery bit starts a flush. For a fixed number of cycles the unit drives a reset to the sequencer, empties the FIFO and ignores pushes and pops. The recovery bit reads back as 1 for the whole flush and then clears itself. The flush leaves the raw status untouched, so software clears it on its own afterwards.

Top module: `flash_irq_ctl`

## Requirements
- R1: After reset the mask reads 0xFF, raw and masked status read 0, the threshold reads 0, the recovery bit reads 0, the FIFO status reads 0x6 (both empty flags set), and irq and seq_rst are low.
- R2: A 1 on any evt_in bit sets the matching raw status bit at the next clock edge, whatever the mask holds. The bit stays set until it is cleared.
- R3: Writing to the clear register (word 1) clears each raw bit whose write bit is 1 and leaves the other raw bits alone. The clear register reads 0.
- R4: If a raw bit's event arrives in the same cycle as a clear of that bit, the bit stays set.
- R5: Masked status (word 4) equals raw status (word 6) AND NOT mask (word 0), where a mask bit of 1 blocks its source. irq is high exactly when any masked bit is 1.
- R6: The FIFO status register (word 5) has these fields: bit 0 transmit full, bit 1 transmit empty, bit 2 receive empty, bit 3 receive full, bits 12:8 transmit level, bits 20:16 receive level. Both level fields carry the same shared occupancy.
- R7: FIFO events use these raw bits. A push that makes the FIFO full sets bit 0. A pop on an empty FIFO sets bit 1. A push on a full FIFO is dropped and sets bit 2. A pop that leaves the FIFO empty sets bit 3.
- R8: pop_data shows the oldest stored word. Words leave the FIFO in the order they were pushed.
- R9: The threshold register (word 2) stores a transmit threshold in bits 4:0 and a receive threshold in bits 12:8. All its other bits read 0.
- R10: Writing 1 to bit 0 of the recovery register (word 3) makes that bit read 1, and holds seq_rst high, for exactly FLUSH_CYCLES cycles. Both then clear on their own. The flush leaves the FIFO empty, and pushes made during it are ignored.
- R11: A recovery flush does not change raw status.
- R12: A write to the recovery register with bit 0 clear starts nothing. The recovery bit and seq_rst stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| evt_in | input | 8 | Event pulses from the sequencer, one per raw bit |
| push | input | 1 | Push push_data into the FIFO |
| push_data | input | 32 | Word to push |
| pop | input | 1 | Pop the oldest word |
| pop_data | output | 32 | Oldest word in the FIFO |
| irq | output | 1 | OR of the masked status bits |
| seq_rst | output | 1 | Reset to the sequencer while a flush runs |

## Verification
The bench drives an event and a clear of the same bit in one cycle. A design where the clear wins would read that raw bit back as 0. It pushes one word past full and pops once past empty. A design that overwrites stored data or lets the level wrap would show a level other than 16, and a design that does not flag these cases would leave raw bits 1 and 2 low. The bench also counts how many cycles the recovery bit stays high while it keeps pushing into the flush. It expects exactly FLUSH_CYCLES cycles, an empty FIFO and unchanged raw status. Any one of these faults breaks that check: a flush that is too short, one that accepts data, or one that wipes the raw status.

// File: rtl/flash_irq_ctl.sv
module flash_irq_ctl #(
  parameter int DEPTH        = 16,
  parameter int DW           = 32,
  parameter int FLUSH_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [7:0]    evt_in,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic          irq,
  output logic          seq_rst
);
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int FCW = $clog2(FLUSH_CYCLES + 1);

  localparam logic [2:0] A_MASK  = 3'd0;
  localparam logic [2:0] A_CLR   = 3'd1;
  localparam logic [2:0] A_THR   = 3'd2;
  localparam logic [2:0] A_RCVR  = 3'd3;
  localparam logic [2:0] A_MSTAT = 3'd4;
  localparam logic [2:0] A_FSTAT = 3'd5;
  localparam logic [2:0] A_RAW   = 3'd6;

  logic [7:0]     mask_q, raw_q;
  logic [4:0]     txthr_q, rxthr_q;
  logic           busy_q;
  logic [FCW-1:0] fcnt_q;
  logic [DW-1:0]  mem [DEPTH];
  logic [PW-1:0]  wp_q, rp_q;
  logic [CW-1:0]  cnt_q;

  wire full    = (cnt_q == CW'(DEPTH));
  wire empty   = (cnt_q == '0);
  wire do_push = push && !busy_q && !full;
  wire do_pop  = pop && !busy_q && !empty;

  wire ev_ovf  = push && !busy_q && full;
  wire ev_udf  = pop && !busy_q && empty;
  wire ev_full = do_push && !do_pop && (cnt_q == CW'(DEPTH - 1));
  wire ev_mt   = do_pop && !do_push && (cnt_q == CW'(1));

  wire [7:0] set_vec = evt_in | {4'b0, ev_mt, ev_ovf, ev_udf, ev_full};
  wire [7:0] clr_vec = (reg_we && reg_addr == A_CLR) ? reg_wdata[7:0] : 8'h00;
  wire       start   = reg_we && reg_addr == A_RCVR && reg_wdata[0] && !busy_q;

  wire [7:0] mstat = raw_q & ~mask_q;
  wire [4:0] lvl   = 5'(cnt_q);

  assign irq      = |mstat;
  assign seq_rst  = busy_q;
  assign pop_data = mem[rp_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= 8'hFF;
      raw_q   <= 8'h00;
      txthr_q <= '0;
      rxthr_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_vec) | set_vec;
      if (reg_we && reg_addr == A_MASK) mask_q <= reg_wdata[7:0];
      if (reg_we && reg_addr == A_THR) begin
        txthr_q <= reg_wdata[4:0];
        rxthr_q <= reg_wdata[12:8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      fcnt_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      fcnt_q <= FCW'(FLUSH_CYCLES - 1);
    end else if (busy_q) begin
      if (fcnt_q == '0) busy_q <= 1'b0;
      else              fcnt_q <= fcnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (busy_q) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= push_data;
  end

  always_comb begin
    reg_rdata = 32'h0;
    case (reg_addr)
      A_MASK:  reg_rdata = {24'h0, mask_q};
      A_THR:   reg_rdata = {19'h0, rxthr_q, 3'h0, txthr_q};
      A_RCVR:  reg_rdata = {31'h0, busy_q};
      A_MSTAT: reg_rdata = {24'h0, mstat};
      A_FSTAT: reg_rdata = {11'h0, lvl, 3'h0, lvl, 4'h0, full, empty, empty, full};
      A_RAW:   reg_rdata = {24'h0, raw_q};
      default: reg_rdata = 32'h0;
    endcase
  end

  initial begin
    assert (DEPTH >= 2 && DEPTH <= 31) else $error("DEPTH out of range");
    assert (FLUSH_CYCLES >= 1) else $error("FLUSH_CYCLES out of range");
  end

  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != 8'h00) |=> ((raw_q & $past(set_vec)) == $past(set_vec)));

  p_event_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & clr_vec) != 8'h00) |=> ((raw_q & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)));

  p_clear_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != 8'h00) |=> ((raw_q & $past(clr_vec & ~set_vec)) == 8'h00));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> (cnt_q == '0));

  p_flush_keeps_raw_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && set_vec == 8'h00 && clr_vec == 8'h00) |=> $stable(raw_q));
endmodule

// File: tb/tb_flash_irq_ctl.sv
module tb_flash_irq_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int FLUSH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic [7:0]  evt_in = 8'h00;
  logic        push = 1'b0;
  logic [31:0] push_data = 32'h0;
  logic        pop = 1'b0;
  logic [31:0] pop_data;
  logic        irq, seq_rst;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  flash_irq_ctl #(.DEPTH(DEPTH), .DW(32), .FLUSH_CYCLES(FLUSH)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
    .push(push), .push_data(push_data), .pop(pop), .pop_data(pop_data),
    .irq(irq), .seq_rst(seq_rst));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic pulse_evt(input logic [7:0] e);
    @(negedge clk);
    evt_in = e;
    @(negedge clk);
    evt_in = 8'h00;
  endtask

  task automatic push_word(input logic [31:0] d);
    @(negedge clk);
    push = 1'b1; push_data = d;
    @(negedge clk);
    push = 1'b0;
  endtask

  task automatic pop_check(input string tag, input logic [31:0] exp);
    @(negedge clk);
    #1;
    chk(tag, pop_data, exp);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic t_reset;
    rd("R1 mask", 3'd0, 32'hFF);
    rd("R1 raw", 3'd6, 32'h0);
    rd("R1 masked", 3'd4, 32'h0);
    rd("R1 thr", 3'd2, 32'h0);
    rd("R1 rcvr", 3'd3, 32'h0);
    rd("R1 fstat", 3'd5, 32'h6);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 seq_rst", {31'h0, seq_rst}, 32'h0);
  endtask

  task automatic t_events;
    pulse_evt(8'h30);
    rd("R2 raw while masked", 3'd6, 32'h30);
    rd("R5 masked all", 3'd4, 32'h0);
    chk("R5 irq masked", {31'h0, irq}, 32'h0);
    wr(3'd0, 32'hEF);
    rd("R5 masked one", 3'd4, 32'h10);
    chk("R5 irq on", {31'h0, irq}, 32'h1);
    wr(3'd1, 32'h10);
    rd("R3 clear one", 3'd6, 32'h20);
    chk("R5 irq off", {31'h0, irq}, 32'h0);
    wr(3'd1, 32'h00);
    rd("R3 zero write", 3'd6, 32'h20);
    rd("R3 clr reads 0", 3'd1, 32'h0);
    wr(3'd1, 32'h20);
    rd("R3 all cleared", 3'd6, 32'h0);
    wr(3'd0, 32'hFF);
  endtask

  task automatic t_collide;
    @(negedge clk);
    evt_in = 8'h40; reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h40;
    @(negedge clk);
    evt_in = 8'h00; reg_we = 1'b0;
    rd("R4 event wins", 3'd6, 32'h40);
    wr(3'd1, 32'hFF);
    rd("R4 cleared after", 3'd6, 32'h0);
  endtask

  task automatic t_fifo;
    push_word(32'hA0A0_0001);
    push_word(32'hB0B0_0002);
    push_word(32'hC0C0_0003);
    rd("R6 level 3", 3'd5, 32'h0003_0300);
    pop_check("R8 first", 32'hA0A0_0001);
    pop_check("R8 second", 32'hB0B0_0002);
    rd("R7 not yet empty", 3'd6, 32'h0);
    pop_check("R8 third", 32'hC0C0_0003);
    rd("R7 drain sets bit3", 3'd6, 32'h08);
    rd("R6 empty again", 3'd5, 32'h6);
    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0;
    rd("R7 underflow bit1", 3'd6, 32'h0A);
    rd("R6 still empty", 3'd5, 32'h6);
    for (int i = 0; i < DEPTH; i++) push_word(32'h100 + i);
    rd("R6 full", 3'd5, 32'h0010_1009);
    rd("R7 fill sets bit0", 3'd6, 32'h0B);
    push_word(32'hDEAD_BEEF);
    rd("R7 overflow bit2", 3'd6, 32'h0F);
    rd("R7 level held", 3'd5, 32'h0010_1009);
    pop_check("R8 oldest after full", 32'h100);
    rd("R6 level 15", 3'd5, 32'h000F_0F00);
    wr(3'd1, 32'hFF);
  endtask

  task automatic t_thr;
    wr(3'd2, 32'hFFFF_FFFF);
    rd("R9 unused bits zero", 3'd2, 32'h1F1F);
    wr(3'd2, 32'h0000_0A05);
    rd("R9 fields", 3'd2, 32'h0A05);
  endtask

  task automatic t_recovery;
    int n;
    pulse_evt(8'h80);
    rd("R11 raw before", 3'd6, 32'h80);
    wr(3'd3, 32'h0000_0002);
    rd("R12 bit0 clear no start", 3'd3, 32'h0);
    chk("R12 seq_rst low", {31'h0, seq_rst}, 32'h0);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h1;
    @(negedge clk);
    reg_we = 1'b0;
    push = 1'b1; push_data = 32'h5555_AAAA;
    n = 0;
    reg_addr = 3'd3;
    #1;
    chk("R10 seq_rst high", {31'h0, seq_rst}, 32'h1);
    while (reg_rdata[0] === 1'b1 && n < 20) begin
      n++;
      @(negedge clk);
      if (n == 2) push = 1'b0;
      #1;
    end
    push = 1'b0;
    chk("R10 busy cycles", n, FLUSH);
    chk("R10 seq_rst released", {31'h0, seq_rst}, 32'h0);
    rd("R10 fifo empty", 3'd5, 32'h6);
    rd("R11 raw kept", 3'd6, 32'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_events();
    t_collide();
    t_fifo();
    t_thr();
    t_recovery();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule